// File: doc/BRIEF.md
# Reloadable System Tick Timer

A periodic down-counter with a small word-addressed register bus and one interrupt-request output. When enabled, the count register loses one on every clock. When it holds zero it takes a fresh start value from the reload register. The step from one to zero is the tick event. A tick event sets a sticky status flag and, if interrupts are enabled, produces a one-cycle interrupt pulse. Software programs a period of N clocks by writing N-1 as the start value.

The bus is plain control access, not a stream. It has no handshake and never stalls. A write takes effect at the next rising clock edge. Read data is combinational: it reflects the addressed register during the cycle the read strobe is high. The read side effect (clearing the flag) happens at the following edge. Reading and writing in the same cycle is allowed, and the two act independently. The calibration word is a fixed parameter, because the block has no reference clock to measure.

Top module: `tick_timer`

## Requirements
- R1: After reset, enable, interrupt-enable and the flag are 0, the reload and count registers are 0, and the interrupt output is low.
- R2: The word address selects the register: 0 is control/status, 1 is reload, 2 is count, 3 is calibration. In the control/status word, bit 0 is enable, bit 1 is interrupt-enable and bit 16 is the flag; all other bits read 0. Bits 31:24 of the reload and count words read 0.
- R3: While enabled, the count drops by one per clock, and a count of zero loads the reload value on the next clock.
- R4: A reload value of N-1 gives one tick event every N clocks.
- R5: The flag sets only on a step from 1 to 0. It stays set until the control/status word is read; that read returns 1 and clears the flag. If a tick event and a clearing access fall in the same cycle, the set wins.
- R6: The interrupt output is high for exactly the one cycle after a tick event, and only if interrupt-enable is 1. With interrupt-enable at 0 it stays low.
- R7: With a reload value of 0, the count stays at 0 and no flag or interrupt is ever produced.
- R8: A write of any data to the count word clears the count to 0 and clears the flag. No tick event occurs in that cycle.
- R9: While disabled, the count holds its value.
- R10: The calibration word reads the CALIB_VALUE parameter. Writes to it change nothing.
- R11: A reload write does not disturb the count in progress. The new value is used at the next load from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
The hardest cases to reach from the ports are collisions: a tick event in the same cycle as a flag-clearing read, or as a count write. Each of these needs the count to sit exactly at 1 when the bus access lands. The random phase therefore keeps reload values small (mostly 0 to 15) and issues a bus access on most cycles. This makes such overlaps frequent, and a cycle-accurate bench model predicts every read and every interrupt cycle. Directed cases cover the 100-cycle period, the inert zero reload and the mid-count reload write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_FLAG_BIT = 16;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_COUNT = 2'd2,
    REG_CAL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;
  logic             at_one;

  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == ONE);
  // tick event: an enabled step from 1 down to 0, not overridden by a clear
  assign wrap_o  = run_i && !clear_i && at_one;
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= at_zero ? reload_i : (cnt_q - ONE);
  end

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i && !at_zero) |=> (count_o == $past(count_o) - ONE));
  p_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i && at_zero) |=> (count_o == $past(reload_i)));
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clear_i) |=> $stable(count_o));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic              count_clr_o,
  output logic [CNT_W-1:0]  reload_o
);
  logic ctrl_wr, load_wr, ctrl_rd;
  logic unused_wdata_hi;

  assign ctrl_wr     = wr_i && (sel_i == REG_CTRL);
  assign load_wr     = wr_i && (sel_i == REG_LOAD);
  assign count_clr_o = wr_i && (sel_i == REG_COUNT);
  assign ctrl_rd     = rd_i && (sel_i == REG_CTRL);
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o <= 1'b0;
      ie_o <= 1'b0;
    end else if (ctrl_wr) begin
      en_o <= wdata_i[CTRL_EN_BIT];
      ie_o <= wdata_i[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       reload_o <= '0;
    else if (load_wr) reload_o <= wdata_i[CNT_W-1:0];
  end

  // set has priority over either clearing access
  always_ff @(posedge clk) begin
    if (!rst_n)                       flag_o <= 1'b0;
    else if (wrap_i)                  flag_o <= 1'b1;
    else if (ctrl_rd || count_clr_o)  flag_o <= 1'b0;
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_o);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !ctrl_rd && !count_clr_o) |=> flag_o);
  p_flag_only_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !wrap_i) |=> !flag_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int          CNT_W       = 24,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] CALIB_VALUE = 32'h4000_2710
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  reg_sel_e         sel;
  logic             en, ie, flag, count_clr, wrap;
  logic [CNT_W-1:0] reload, count;
  logic             irq_q;

  assign sel = reg_sel_e'(bus_addr);

  tick_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd), .wr_i(bus_wr), .sel_i(sel),
    .wdata_i(bus_wdata), .wrap_i(wrap), .en_o(en), .ie_o(ie), .flag_o(flag),
    .count_clr_o(count_clr), .reload_o(reload)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_i(en), .clear_i(count_clr),
    .reload_i(reload), .count_o(count), .wrap_o(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap && ie;
  end
  assign tick_irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = en;
        bus_rdata[CTRL_IE_BIT]   = ie;
        bus_rdata[CTRL_FLAG_BIT] = flag;
      end
      REG_LOAD:  bus_rdata[CNT_W-1:0] = reload;
      REG_COUNT: bus_rdata[CNT_W-1:0] = count;
      REG_CAL:   bus_rdata = DATA_W'(CALIB_VALUE);
    endcase
  end

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);
  p_irq_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (count == '0) && flag);
  p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie || !en) |=> !tick_irq);
  p_zero_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && count == '0) |=> (count == '0));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CAL = 32'h4000_2710;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer #(.CALIB_VALUE(CAL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq)
  );

  int vectors = 0, errors = 0;
  bit done = 0;
  // bench model
  bit          m_en, m_ie, m_flag, m_irq;
  logic [23:0] m_rel, m_cur;
  int          cyc = 0, last_irq = -1, gap = 0, irq_seen = 0;

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[0] = m_en; v[1] = m_ie; v[16] = m_flag; end
      2'd1: v[23:0] = m_rel;
      2'd2: v[23:0] = m_cur;
      default: v = CAL;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [31:0] d, input string tag);
    bit ev;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    check("R6 irq", {31'd0, tick_irq}, {31'd0, m_irq});
    if (tick_irq) begin
      irq_seen++;
      if (last_irq >= 0) gap = cyc - last_irq;
      last_irq = cyc;
    end
    if (rd) check(tag, bus_rdata, exp_rdata(a));
    ev = m_en && !(wr && a == 2'd2) && m_cur == 24'd1;
    @(posedge clk);
    cyc++;
    m_irq = ev && m_ie;
    if (wr && a == 2'd2) m_cur = '0;
    else if (m_en) m_cur = (m_cur == 0) ? m_rel : m_cur - 24'd1;
    if (ev) m_flag = 1;
    else if ((rd && a == 2'd0) || (wr && a == 2'd2)) m_flag = 0;
    if (wr && a == 2'd0) begin m_en = d[0]; m_ie = d[1]; end
    if (wr && a == 2'd1) m_rel = d[23:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 32'd0, "");
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    m_en = 0; m_ie = 0; m_flag = 0; m_irq = 0; m_rel = 0; m_cur = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state, R2 map, R10 calibration
    step(1, 0, 2'd0, 0, "R1 ctrl reset");
    step(1, 0, 2'd1, 0, "R1 reload reset");
    step(1, 0, 2'd2, 0, "R1 count reset");
    step(1, 0, 2'd3, 0, "R10 calib");
    step(0, 1, 2'd3, 32'hFFFF_FFFF, "");
    step(1, 0, 2'd3, 0, "R10 calib after write");
    // R2 upper bits zero, R7 zero reload inert
    step(0, 1, 2'd1, 32'hFFFF_FFFF, "");
    step(1, 0, 2'd1, 0, "R2 reload upper zero");
    step(0, 1, 2'd0, 32'hFFFF_FFFF, "");
    step(1, 0, 2'd0, 0, "R2 ctrl bits");
    step(0, 1, 2'd0, 32'd0, "");
    step(0, 1, 2'd1, 32'd0, "");
    step(0, 1, 2'd2, 32'd0, "");
    step(0, 1, 2'd0, 32'd3, "");
    idle(40);
    step(1, 0, 2'd2, 0, "R7 count stays zero");
    step(1, 0, 2'd0, 0, "R7 no flag");
    check("R7 no irq", irq_seen, 0);
    // R4 period 100 with reload 99, R3 count readback
    step(0, 1, 2'd1, 32'd99, "");
    idle(5);
    step(1, 0, 2'd2, 0, "R3 counting down");
    idle(250);
    check("R4 period", gap, 100);
    step(1, 0, 2'd0, 0, "R5 flag read");
    step(1, 0, 2'd0, 0, "R5 flag cleared");
    // R6 interrupt disabled
    irq_seen = 0;
    step(0, 1, 2'd0, 32'd1, "");
    idle(210);
    check("R6 no irq with ie clear", irq_seen, 0);
    step(1, 0, 2'd0, 0, "R5 flag still sets");
    // R9 hold while disabled
    step(0, 1, 2'd0, 32'd0, "");
    step(1, 0, 2'd2, 0, "R9 hold a");
    idle(7);
    step(1, 0, 2'd2, 0, "R9 hold b");
    // R8 count write clears
    step(0, 1, 2'd0, 32'd1, "");
    idle(20);
    step(0, 1, 2'd2, 32'hFFFF_FFFF, "");
    step(1, 0, 2'd2, 0, "R8 count cleared");
    step(1, 0, 2'd0, 0, "R8 flag state");
    // R11 reload write mid-count
    step(0, 1, 2'd1, 32'd50, "");
    step(0, 1, 2'd2, 0, "");
    idle(10);
    step(0, 1, 2'd1, 32'd7, "");
    step(1, 0, 2'd2, 0, "R11 count undisturbed");
    idle(45);
    step(1, 0, 2'd2, 0, "R11 new reload used");
    // random phase, small reloads to force collisions
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] d = $urandom;
      logic [1:0]  a = r[1:0];
      if (a == 2'd1) d = (r[7:4] == 0) ? d : {28'd0, d[3:0]};
      if (r[10:8] < 3)      step(0, 0, a, d, "");
      else if (r[10:8] < 6) step(1, 0, a, d, "R3 R5 random read");
      else if (r[11])       step(0, 1, a, d, "");
      else                  step(1, 1, a, d, "R5 R8 random rd+wr");
    end
    report();
  end
endmodule